// File: doc/BRIEF.md
# DDS Phase Accumulator with Clear Controls

This block is the phase engine of a direct digital synthesizer. Every clock it adds a 32-bit frequency tuning word to a wrapping phase register. The top 16 bits of that register form the address for a downstream sine lookup. Next to the address it drives a flag that tells the lookup stage whether to produce sine or cosine.

Software-facing values arrive on plain input pins: the tuning word, the autoclear bit, the hold-clear bit, the sine-select bit and the 2-bit mode field. None of these takes effect until a transfer strobe fires. Two strobes can transfer them: the update strobe and the profile-change strobe. The two strobes behave the same way.

There are two ways to clear the phase:
- **Hold-clear.** While the transferred hold-clear bit is set, the phase is pinned at zero.
- **Autoclear.** When the autoclear bit is set, the strobe itself zeroes the phase. Accumulation then restarts with the new tuning word.

Top module: `dds_phase_core`

## Requirements
- R1: While no clear is active and no strobe fires, the phase register gains the transferred tuning word on every rising clock edge, wrapping modulo 2^32 with no flag.
- R2: Input values for tuning word, autoclear, hold-clear, sine-select and mode are ignored on edges where neither `upd_stb` nor `prof_stb` is high; they are taken on an edge where either is high and act from that edge on.
- R3: On an edge where a strobe is high and `autoclr_in` is 1, the phase register becomes zero; on the next edge it holds the newly transferred tuning word.
- R4: On an edge where a strobe is high and `autoclr_in` is 0, the phase register is not cleared and instead adds the newly transferred tuning word.
- R5: While the transferred hold-clear bit is 1 (including the edge that transfers it), the phase register reads zero each cycle; after a strobe transfers 0, accumulation resumes from zero.
- R6: When a clear and the add fall on the same edge, the clear wins and the register loads zero regardless of the tuning word.
- R7: `phase_addr` equals bits 31..16 of the phase register.
- R8: `sin_sel_out` is 1 only when the transferred mode is 01 (single tone) and the transferred sine-select bit is 1. Sine-select 0 means cosine. Modes 00 (quadrature) and 1x (interpolating DAC) always give 0.
- R9: After synchronous active-low reset, the phase register, the tuning word and all control bits are zero, so `phase_addr` is 0 and `sin_sel_out` is 0.
- R10: `prof_stb` transfers values and triggers autoclear exactly as `upd_stb` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ftw_in | input | 32 | Pending frequency tuning word |
| autoclr_in | input | 1 | Pending autoclear-on-strobe bit |
| hold_clr_in | input | 1 | Pending level hold-clear bit |
| sin_sel_in | input | 1 | Pending output select, 1 = sine, 0 = cosine |
| mode_in | input | 2 | Pending mode: 00 quadrature, 01 single tone, 1x interpolating DAC |
| upd_stb | input | 1 | Update strobe, transfers pending values |
| prof_stb | input | 1 | Profile-change strobe, transfers pending values |
| phase_addr | output | 16 | Lookup address, upper phase bits |
| sin_sel_out | output | 1 | Sine/cosine flag to the lookup stage |

## Verification
A wrong transferred tuning word or a missed clear shows at `phase_addr` on the very next edge whenever the word has bits at or above bit 16. Words below that only move the address after carries build up. For that reason the bench mixes large and small words.

A control bit latched at the wrong time shows within one cycle on `sin_sel_out`, or as a nonzero address while hold-clear should pin it. A wrong carry or wrap in the accumulator diverges from the bench's modulo-2^32 model and never recovers until the next clear. Every cycle is compared against that model.

// File: rtl/dds_acc_pkg.sv
// Package: shared types and codes for the DDS phase accumulator.
// Assumes: mode field is 2 bits; the upper mode bit alone selects the
// interpolating DAC mode.
package dds_acc_pkg;

    localparam logic [1:0] MODE_QUAD = 2'b00;
    localparam logic [1:0] MODE_TONE = 2'b01;

    // Control bits that travel together from pending to active state
    typedef struct packed {
        logic       autoclr;
        logic       hold_clr;
        logic       sin_sel;
        logic [1:0] mode;
    } dds_ctl_t;

    localparam dds_ctl_t CTL_RESET = '{autoclr: 1'b0, hold_clr: 1'b0,
                                       sin_sel: 1'b0, mode: MODE_QUAD};

endpackage

// File: rtl/dds_cfg_xfer.sv
// Module: dds_cfg_xfer
// Holds the active tuning word and control bits. Pending inputs are copied
// to the active set on any edge where a transfer strobe is high.
// Also presents the "effective" values for the current edge: the pending
// values when a strobe is high, the active ones otherwise. The accumulator
// therefore sees new settings on the strobe edge itself.
// Assumes: strobes are single-cycle or level; each high edge transfers.
module dds_cfg_xfer
    import dds_acc_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] ftw_in,
    input  dds_ctl_t         ctl_in,
    input  logic             upd_stb,
    input  logic             prof_stb,
    output logic             xfer,
    output logic [ACC_W-1:0] ftw_act,
    output dds_ctl_t         ctl_act,
    output logic [ACC_W-1:0] ftw_eff,
    output logic             clr_eff
);

    assign xfer = upd_stb | prof_stb;

    // Transfer pending settings into the active set on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftw_act <= '0;
            ctl_act <= CTL_RESET;
        end else if (xfer) begin
            ftw_act <= ftw_in;
            ctl_act <= ctl_in;
        end
    end

    // Select the settings seen by the accumulator on this edge
    always_comb begin
        if (xfer) begin
            ftw_eff = ftw_in;
            clr_eff = ctl_in.hold_clr | ctl_in.autoclr;
        end else begin
            ftw_eff = ftw_act;
            clr_eff = ctl_act.hold_clr;
        end
    end

endmodule

// File: rtl/dds_phase_acc.sv
// Module: dds_phase_acc
// Wrapping phase register: adds the step each clock, or loads zero when
// clr is high (clear has priority over the add).
// Assumes: overflow is discarded; no saturation.
module dds_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] acc_q
);

    // Accumulate modulo 2^ACC_W, clear wins
    always_ff @(posedge clk) begin
        if (!rst_n)   acc_q <= '0;
        else if (clr) acc_q <= '0;
        else          acc_q <= acc_q + step;
    end

endmodule

// File: rtl/dds_out_sel.sv
// Module: dds_out_sel
// Truncates the phase to the lookup address and derives the sine/cosine
// flag. The select bit counts only in single-tone mode.
// Assumes: ADDR_W <= ACC_W; address is the top ADDR_W phase bits.
module dds_out_sel
    import dds_acc_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 16
) (
    input  logic [ACC_W-1:0]  acc_q,
    input  dds_ctl_t          ctl_act,
    output logic [ADDR_W-1:0] phase_addr,
    output logic              sin_sel_out
);

    localparam int LSB = ACC_W - ADDR_W;

    generate
        if (LSB > 0) begin : g_trunc
            assign phase_addr = acc_q[ACC_W-1:LSB];
        end else begin : g_full
            assign phase_addr = acc_q;
        end
    endgenerate

    // Sine only in single-tone mode with select set; cosine otherwise
    always_comb begin
        sin_sel_out = (ctl_act.mode == MODE_TONE) && ctl_act.sin_sel;
    end

endmodule

// File: rtl/dds_phase_core.sv
// Module: dds_phase_core (top)
// DDS phase accumulator with a hold-clear and a strobe-keyed autoclear.
// Settings take effect on an update or profile-change strobe.
// Assumes: synchronous active-low reset; strobes sampled on rising edge.
module dds_phase_core
    import dds_acc_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  ftw_in,
    input  logic              autoclr_in,
    input  logic              hold_clr_in,
    input  logic              sin_sel_in,
    input  logic [1:0]        mode_in,
    input  logic              upd_stb,
    input  logic              prof_stb,
    output logic [ADDR_W-1:0] phase_addr,
    output logic              sin_sel_out
);

    dds_ctl_t         ctl_in;
    dds_ctl_t         ctl_act;
    logic             xfer;
    logic [ACC_W-1:0] ftw_act;
    logic [ACC_W-1:0] ftw_eff;
    logic             clr_eff;
    logic [ACC_W-1:0] acc_q;

    assign ctl_in = '{autoclr: autoclr_in, hold_clr: hold_clr_in,
                      sin_sel: sin_sel_in, mode: mode_in};

    dds_cfg_xfer #(.ACC_W(ACC_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .ftw_in(ftw_in), .ctl_in(ctl_in),
        .upd_stb(upd_stb), .prof_stb(prof_stb), .xfer(xfer),
        .ftw_act(ftw_act), .ctl_act(ctl_act),
        .ftw_eff(ftw_eff), .clr_eff(clr_eff)
    );

    dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(clr_eff), .step(ftw_eff),
        .acc_q(acc_q)
    );

    dds_out_sel #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_out (
        .acc_q(acc_q), .ctl_act(ctl_act),
        .phase_addr(phase_addr), .sin_sel_out(sin_sel_out)
    );

    // Plain step: phase advances by the active word
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer && !ctl_act.hold_clr) |=> (acc_q == $past(acc_q) + $past(ftw_act)));

    // Active settings only move on a strobe
    p_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> ($stable(ftw_act) && $stable(ctl_act)));

    // Strobe with autoclear set zeroes the phase (clear beats the add)
    p_autoclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && autoclr_in) |=> (acc_q == '0));

    // Hold-clear pins the phase at zero
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_act.hold_clr && !xfer) |=> (acc_q == '0));

    // Sine flag can only turn on right after a transfer
    p_sine_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sin_sel_out) |-> $past(xfer));

endmodule

// File: tb/test_dds_phase_core.sv
`timescale 1ns/1ps
module test_dds_phase_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ftw_in = '0;
    logic        autoclr_in = 1'b0;
    logic        hold_clr_in = 1'b0;
    logic        sin_sel_in = 1'b0;
    logic [1:0]  mode_in = 2'b00;
    logic        upd_stb = 1'b0;
    logic        prof_stb = 1'b0;
    logic [15:0] phase_addr;
    logic        sin_sel_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // bench model state
    logic [31:0] m_acc = '0, m_ftw = '0;
    logic        m_ac = 0, m_hold = 0, m_sel = 0;
    logic [1:0]  m_mode = 2'b00;

    always #2 clk = ~clk;

    dds_phase_core i_dds_phase_core (
        .clk(clk), .rst_n(rst_n), .ftw_in(ftw_in), .autoclr_in(autoclr_in),
        .hold_clr_in(hold_clr_in), .sin_sel_in(sin_sel_in), .mode_in(mode_in),
        .upd_stb(upd_stb), .prof_stb(prof_stb),
        .phase_addr(phase_addr), .sin_sel_out(sin_sel_out)
    );

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic exp_sin(input logic [1:0] md, input logic sl);
        return (md == 2'b01) && sl;
    endfunction

    task automatic check_out(input string tag);
        checks++;
        if (phase_addr !== m_acc[31:16]) begin
            errors++;
            $display("FAIL %s phase_addr: actual %h expected %h", tag, phase_addr, m_acc[31:16]);
        end
        checks++;
        if (sin_sel_out !== exp_sin(m_mode, m_sel)) begin
            errors++;
            $display("FAIL %s sin_sel_out: actual %b expected %b", tag, sin_sel_out, exp_sin(m_mode, m_sel));
        end
    endtask

    // One cycle: drive at negedge, update model at posedge, check at next negedge
    task automatic step(input logic [31:0] f, input logic ac, input logic hd,
                        input logic sl, input logic [1:0] md,
                        input logic up, input logic pr, input string tag);
        logic st, clr;
        logic [31:0] fe;
        ftw_in = f; autoclr_in = ac; hold_clr_in = hd; sin_sel_in = sl;
        mode_in = md; upd_stb = up; prof_stb = pr;
        @(posedge clk);
        st  = up | pr;
        fe  = st ? f : m_ftw;
        clr = st ? (hd | ac) : m_hold;
        m_acc = clr ? 32'h0 : m_acc + fe;
        if (st) begin
            m_ftw = f; m_ac = ac; m_hold = hd; m_sel = sl; m_mode = md;
        end
        @(negedge clk);
        check_out(tag);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R9: reset state
        check_out("R9");
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R9");

        // R4: load word without autoclear, then plain steps R1 and R7
        step(32'h0001_0000, 0, 0, 0, 2'b00, 1, 0, "R4");
        for (int i = 0; i < 5; i++) step(32'h0, 0, 0, 0, 2'b00, 0, 0, "R1");
        // R2: pending inputs without strobe are ignored
        for (int i = 0; i < 4; i++) step(32'hFFFF_0000, 1, 1, 1, 2'b01, 0, 0, "R2");
        // R3/R6: autoclear on update with a nonzero word
        step(32'h1234_5678, 1, 0, 0, 2'b00, 1, 0, "R3");
        step(32'h0, 0, 0, 0, 2'b00, 0, 0, "R3");
        step(32'h0, 0, 0, 0, 2'b00, 0, 0, "R6");
        // R10: profile-change strobe also autoclears and transfers
        step(32'h0800_0000, 1, 0, 1, 2'b01, 0, 1, "R10");
        step(32'h0, 0, 0, 0, 2'b00, 0, 0, "R10");
        // R1: wrap modulo 2^32
        for (int i = 0; i < 40; i++) step(32'h0, 0, 0, 0, 2'b00, 0, 0, "R1");
        // R5: hold-clear held, then released
        step(32'h0300_0000, 0, 1, 0, 2'b01, 1, 0, "R5");
        for (int i = 0; i < 4; i++) step(32'h0, 0, 0, 0, 2'b00, 0, 0, "R5");
        step(32'h0300_0000, 0, 0, 1, 2'b10, 1, 0, "R5");
        step(32'h0, 0, 0, 0, 2'b00, 0, 0, "R8");
        // R8: mode 11 with select, then single tone cosine
        step(32'h0000_4000, 0, 0, 1, 2'b11, 1, 0, "R8");
        step(32'h0000_4000, 0, 0, 0, 2'b01, 0, 1, "R8");
        step(32'h0000_4000, 0, 0, 1, 2'b01, 1, 0, "R8");

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] f;
            logic up, pr, hd, ac;
            f  = ($urandom_range(0, 1) == 1) ? $urandom : ($urandom & 32'h0003_FFFF);
            up = ($urandom_range(0, 15) == 0);
            pr = ($urandom_range(0, 23) == 0);
            hd = ($urandom_range(0, 9) == 0);
            ac = ($urandom_range(0, 2) == 0);
            step(f, ac, hd, 1'($urandom), 2'($urandom), up, pr, "R1/R7");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule